// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A host writes a character into a one-entry holding stage. When that stage is full, the transmit command enable is set and the clear-to-send input is low, the character moves into a shifting stage at a falling edge of the transmit clock. That move frees the holding stage for the next character. The shifting stage sends a low start bit, 5 to 8 data bits least significant first, an optional parity bit and then the stop bits. Each bit lasts 1, 16 or 64 transmit-clock periods.

Everything runs on one system clock. The transmit clock arrives as a level on the `tx_clk` input, and the block acts on each falling edge it samples. Two flags report the state of the two stages. `tx_rdy` means the holding stage can take a character. `tx_empty` means nothing at all is left to send. A break input forces the line low for as long as it is held.

Top module: `async_tx_flow`

## Requirements
- R1: After reset, `tx_line` is 1, `tx_rdy` is 1 and `tx_empty` is 1.
- R2: A write (`wr_valid` high at a clock edge) is accepted only while `tx_rdy` is 1. A write made while `tx_rdy` is 0 is dropped, and the character already held is the one sent.
- R3: A frame starts with one low start bit. The data bits follow, least significant first. The character length is set by `char_len`: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: With `parity_en` = 1, one parity bit follows the last data bit. With `parity_odd` = 0 the total number of ones in the data and parity bits is even. With `parity_odd` = 1 that total is odd.
- R5: The stop bits are high. `stop_sel` = 00 gives one stop bit, 01 gives one and a half, and 10 or 11 gives two.
- R6: `clk_factor` = 00 makes each bit last 1 transmit-clock period, 01 makes it 16 periods, and 10 or 11 makes it 64 periods. With one and a half stop bits at 16x or 64x, the final stop bit lasts half a bit period. At 1x it lasts a full period.
- R7: `tx_line` changes only in the system-clock cycle that follows a sampled falling edge of `tx_clk`, or after a change of `brk`.
- R8: A character starts only at a falling edge where `tx_en` = 1 and `cts_n` = 0. If either changes after the start, the character still completes.
- R9: `tx_rdy` is 1 exactly when the holding stage is empty. It returns to 1 as soon as a character starts, so the next character can be written during transmission. That next character follows the previous stop bits with no idle gap.
- R10: `tx_empty` is 1 only when the holding stage is empty and no character is being shifted.
- R11: While `brk` is 1, `tx_line` is 0 from the next clock cycle on. When `brk` is released, the line returns to the level the transmitter drives, which is high when idle.
- R12: The character length, parity, stop and factor settings are captured when a character starts. Changing them during that character has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_clk | input | 1 | Transmit clock level; its falling edges pace the bits |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Character to send |
| char_len | input | 2 | Data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_en | input | 1 | Adds a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_sel | input | 2 | 00=1, 01=1.5, 1x=2 stop bits |
| clk_factor | input | 2 | 00=1x, 01=16x, 1x=64x transmit clocks per bit |
| tx_en | input | 1 | Transmit command enable |
| cts_n | input | 1 | Clear to send, active low |
| brk | input | 1 | Forces the line low |
| tx_line | output | 1 | Serial output |
| tx_rdy | output | 1 | Holding stage can take a character |
| tx_empty | output | 1 | Nothing left to send |

## Verification
Two things are hard to see from the ports. One is the shortened final stop bit: an idle line is also high, so a half-length stop bit looks the same as a full one. The other is a gate dropped partway through a character. To expose the half stop bit, the bench writes a second character as soon as `tx_rdy` rises. The next start bit then lands exactly where the shortened stop bit ends, and the recorded period-by-period line shows its length. For the gate, the bench raises `cts_n`, clears `tx_en` and rewrites the settings a few periods into a frame, then expects the frame that was captured at its start.

// File: rtl/async_tx_pkg.sv
`timescale 1ns/1ps
package async_tx_pkg;
    localparam int DATA_W  = 8;
    localparam int MIN_LEN = DATA_W - 3;
    localparam int FRAME_W = DATA_W + 4;
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic [1:0] char_len;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop_sel;
        logic [1:0] fac_sel;
    } tx_cfg_t;
endpackage

// File: rtl/tx_clk_edge.sv
`timescale 1ns/1ps
module tx_clk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_clk,
    output logic fall
);
    logic tclk_d, tclk_q;

    always_comb begin
        tclk_d = tx_clk;
        fall   = tclk_q & ~tx_clk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tclk_q <= 1'b0;
        else        tclk_q <= tclk_d;
    end
endmodule

// File: rtl/tx_hold_reg.sv
`timescale 1ns/1ps
module tx_hold_reg
    import async_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.full = 1'b0;
        end else if (wr_valid && !h_q.full) begin
            h_d.full = 1'b1;
            h_d.data = wr_data;
        end
        full = h_q.full;
        data = h_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end
endmodule

// File: rtl/tx_frame_pack.sv
`timescale 1ns/1ps
module tx_frame_pack
    import async_tx_pkg::*;
#(
    parameter int FACT_MID = 16,
    parameter int FACT_HI  = 64,
    parameter int CNT_W    = $clog2(FACT_HI) + 1
) (
    input  logic [DATA_W-1:0]  data,
    input  tx_cfg_t            cfg,
    output logic [FRAME_W-1:0] frame,
    output logic [IDX_W-1:0]   nbits,
    output logic               half,
    output logic [CNT_W-1:0]   ticks
);
    logic [IDX_W-1:0] len;
    logic             par;

    always_comb begin
        len   = IDX_W'(MIN_LEN) + IDX_W'(cfg.char_len);
        frame = '1;
        frame[0] = 1'b0;
        par   = cfg.par_odd;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(len)) begin
                frame[1 + i] = data[i];
                par = par ^ data[i];
            end
        end
        if (cfg.par_en) frame[len + IDX_W'(1)] = par;
        nbits = IDX_W'(1) + len + IDX_W'(cfg.par_en)
              + ((cfg.stop_sel == 2'b00) ? IDX_W'(1) : IDX_W'(2));
        half  = (cfg.stop_sel == 2'b01) && (cfg.fac_sel != 2'b00);
        case (cfg.fac_sel)
            2'b00:   ticks = CNT_W'(1);
            2'b01:   ticks = CNT_W'(FACT_MID);
            default: ticks = CNT_W'(FACT_HI);
        endcase
    end
endmodule

// File: rtl/tx_serializer.sv
`timescale 1ns/1ps
module tx_serializer
    import async_tx_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start_ok,
    input  logic               brk,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [IDX_W-1:0]   nbits_i,
    input  logic               half_i,
    input  logic [CNT_W-1:0]   ticks_i,
    output logic               load,
    output logic               busy,
    output logic               line
);
    typedef struct packed {
        logic               busy;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] frame;
        logic [IDX_W-1:0]   nbits;
        logic               half;
        logic [CNT_W-1:0]   ticks;
        logic               line;
    } ser_t;

    ser_t             s_d, s_q;
    logic             last;
    logic [CNT_W-1:0] lim;

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        last = (s_q.idx == s_q.nbits - IDX_W'(1));
        lim  = (last && s_q.half) ? (s_q.ticks >> 1) : s_q.ticks;
        if (tick) begin
            if (s_q.busy) begin
                if (s_q.cnt == lim - CNT_W'(1)) begin
                    s_d.cnt = '0;
                    if (last) begin
                        s_d.busy = 1'b0;
                        load     = start_ok;
                    end else begin
                        s_d.idx = s_q.idx + IDX_W'(1);
                    end
                end else begin
                    s_d.cnt = s_q.cnt + CNT_W'(1);
                end
            end else begin
                load = start_ok;
            end
        end
        if (load) begin
            s_d.busy  = 1'b1;
            s_d.idx   = '0;
            s_d.cnt   = '0;
            s_d.frame = frame_i;
            s_d.nbits = nbits_i;
            s_d.half  = half_i;
            s_d.ticks = ticks_i;
        end
        s_d.line = ~brk & (s_d.busy ? s_d.frame[s_d.idx] : 1'b1);
        busy = s_q.busy;
        line = s_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/async_tx_flow.sv
`timescale 1ns/1ps
module async_tx_flow
    import async_tx_pkg::*;
#(
    parameter int FACT_MID = 16,
    parameter int FACT_HI  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_clk,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        char_len,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [1:0]        stop_sel,
    input  logic [1:0]        clk_factor,
    input  logic              tx_en,
    input  logic              cts_n,
    input  logic              brk,
    output logic              tx_line,
    output logic              tx_rdy,
    output logic              tx_empty
);
    localparam int CNT_W = $clog2(FACT_HI) + 1;

    logic               fall_tick;
    logic               take;
    logic               hold_full;
    logic [DATA_W-1:0]  hold_data;
    logic               start_ok;
    logic               busy;
    tx_cfg_t            cfg;
    logic [FRAME_W-1:0] frame;
    logic [IDX_W-1:0]   nbits;
    logic               half;
    logic [CNT_W-1:0]   ticks;

    always_comb begin
        cfg.char_len = char_len;
        cfg.par_en   = parity_en;
        cfg.par_odd  = parity_odd;
        cfg.stop_sel = stop_sel;
        cfg.fac_sel  = clk_factor;
        start_ok     = hold_full & tx_en & ~cts_n;
        tx_rdy       = ~hold_full;
        tx_empty     = ~hold_full & ~busy;
    end

    tx_clk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .tx_clk (tx_clk),
        .fall   (fall_tick)
    );

    tx_hold_reg u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (take),
        .full     (hold_full),
        .data     (hold_data)
    );

    tx_frame_pack #(.FACT_MID(FACT_MID), .FACT_HI(FACT_HI), .CNT_W(CNT_W)) u_pack (
        .data  (hold_data),
        .cfg   (cfg),
        .frame (frame),
        .nbits (nbits),
        .half  (half),
        .ticks (ticks)
    );

    tx_serializer #(.CNT_W(CNT_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (fall_tick),
        .start_ok (start_ok),
        .brk      (brk),
        .frame_i  (frame),
        .nbits_i  (nbits),
        .half_i   (half),
        .ticks_i  (ticks),
        .load     (take),
        .busy     (busy),
        .line     (tx_line)
    );
endmodule

// File: rtl/async_tx_flow_chk.sv
`timescale 1ns/1ps
module async_tx_flow_chk (
    input logic clk,
    input logic rst_n,
    input logic fall_tick,
    input logic busy,
    input logic wr_valid,
    input logic tx_rdy,
    input logic tx_empty,
    input logic tx_line,
    input logic brk,
    input logic tx_en,
    input logic cts_n
);
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !$past(brk)) |-> tx_line);

    assert_line_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_tick && !brk && !$past(brk)) |=> $stable(tx_line));

    assert_start_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_en && !cts_n));

    assert_write_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && tx_rdy) |=> !tx_rdy);

    assert_empty_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_rdy);

    assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> !tx_line);
endmodule

bind async_tx_flow async_tx_flow_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fall_tick (fall_tick),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .tx_rdy    (tx_rdy),
    .tx_empty  (tx_empty),
    .tx_line   (tx_line),
    .brk       (brk),
    .tx_en     (tx_en),
    .cts_n     (cts_n)
);

// File: tb/sim_async_tx_flow.sv
`timescale 1ns/1ps
module sim_async_tx_flow;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cl = 2'b11;
    logic       pe = 1'b0;
    logic       po = 1'b0;
    logic [1:0] ss = 2'b00;
    logic [1:0] fs = 2'b00;
    logic       tx_en = 1'b1;
    logic       cts_n = 1'b0;
    logic       brk = 1'b0;
    logic       tx_line, tx_rdy, tx_empty;

    logic gen_en = 1'b1;
    logic gen_clk = 1'b0;
    logic man_clk = 1'b0;
    wire  tx_clk = gen_en ? gen_clk : man_clk;
    int   ph = 0;
    int   fall_cnt = 0;

    bit   recording = 1'b0;
    bit   rec [0:4095];
    int   rec_n = 0;
    bit   exp_a [0:4095];
    int   exp_n = 0;

    int checks = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    async_tx_flow u0 (
        .clk(clk), .rst_n(rst_n), .tx_clk(tx_clk), .wr_valid(wr_valid), .wr_data(wr_data),
        .char_len(cl), .parity_en(pe), .parity_odd(po), .stop_sel(ss), .clk_factor(fs),
        .tx_en(tx_en), .cts_n(cts_n), .brk(brk),
        .tx_line(tx_line), .tx_rdy(tx_rdy), .tx_empty(tx_empty)
    );

    // transmit clock: 4 system clocks per period; line level sampled just before each fall
    always begin
        @(negedge clk);
        if (gen_en) begin
            ph = ph + 1;
            if (ph == 2) gen_clk = 1'b1;
            if (ph == 4) begin
                if (recording && rec_n < 4096) begin
                    rec[rec_n] = tx_line;
                    rec_n = rec_n + 1;
                end
                gen_clk  = 1'b0;
                fall_cnt = fall_cnt + 1;
                ph = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wait_falls(input int k);
        int t = fall_cnt;
        while (fall_cnt < t + k) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic push_lvl(input bit v, input int n);
        for (int i = 0; i < n; i++) begin
            exp_a[exp_n] = v;
            exp_n = exp_n + 1;
        end
    endtask

    // expected line level per transmit-clock period for one character (R3 R4 R5 R6)
    task automatic build_char(input logic [7:0] d);
        int f = (fs == 2'b00) ? 1 : (fs == 2'b01) ? 16 : 64;
        int len = 5 + int'(cl);
        bit par = po;
        push_lvl(1'b0, f);
        for (int i = 0; i < len; i++) begin
            push_lvl(d[i], f);
            par = par ^ d[i];
        end
        if (pe) push_lvl(par, f);
        push_lvl(1'b1, f);
        if (ss == 2'b01) push_lvl(1'b1, (fs == 2'b00) ? f : f / 2);
        else if (ss[1])  push_lvl(1'b1, f);
    endtask

    task automatic compare_rec(input string req);
        int s = -1;
        int bad = 0;
        for (int i = 0; i < rec_n; i++) begin
            if (s < 0 && rec[i] == 1'b0) s = i;
        end
        if (s < 0) begin
            chk(1'b0, req, "no start bit seen", 0, 1);
        end else begin
            for (int i = 0; i < exp_n; i++) begin
                if (s + i >= rec_n) bad = bad + 1;
                else if (rec[s + i] != exp_a[i]) bad = bad + 1;
            end
            for (int i = s + exp_n; i < rec_n; i++) begin
                if (rec[i] != 1'b1) bad = bad + 1;
            end
            chk(bad == 0, req, "line periods wrong", bad, 0);
        end
    endtask

    // mode 0: plain, 1: gate held then released (R2 R8), 2: gate and settings disturbed mid-frame (R8 R12)
    task automatic run_frames(input string req, input int n, input logic [7:0] a, input logic [7:0] b, input int mode);
        logic [1:0] cl_s = cl;
        logic       pe_s = pe;
        exp_n = 0;
        build_char(a);
        if (n == 2) build_char(b);
        while (!tx_empty) @(negedge clk);
        rec_n = 0;
        recording = 1'b1;
        if (mode == 1) cts_n = 1'b1;
        do_write(a);
        if (mode == 1) begin
            do_write(b);
            wait_falls(16);
            chk(tx_line == 1'b1 && rec[rec_n - 1] == 1'b1, "R8", "line while gated", int'(tx_line), 1);
            chk(tx_rdy == 1'b0 && tx_empty == 1'b0, "R2", "flags while gated", int'({tx_rdy, tx_empty}), 0);
            cts_n = 1'b0;
        end
        if (n == 2) begin
            while (!tx_rdy) @(negedge clk);
            chk(tx_rdy && !tx_empty, "R9", "ready during send", int'({tx_rdy, tx_empty}), 2);
            do_write(b);
        end
        if (mode == 2) begin
            while (!tx_rdy) @(negedge clk);
            wait_falls(3);
            cts_n = 1'b1;
            tx_en = 1'b0;
            cl = ~cl;
            pe = ~pe;
        end
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        wait_falls(3);
        recording = 1'b0;
        compare_rec(req);
        chk(tx_empty && tx_rdy, "R10", "empty after frames", int'({tx_rdy, tx_empty}), 3);
        if (mode == 2) begin
            cts_n = 1'b0;
            tx_en = 1'b1;
            cl = cl_s;
            pe = pe_s;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bad;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b1 && tx_rdy == 1'b1 && tx_empty == 1'b1, "R1", "reset state",
            int'({tx_line, tx_rdy, tx_empty}), 7);

        // R7: output timing relative to a manually driven transmit-clock fall
        gen_en = 1'b0;
        man_clk = 1'b1;
        repeat (2) @(negedge clk);
        fs = 2'b00; cl = 2'b11;
        do_write(8'h0F);
        @(negedge clk);
        chk(tx_line == 1'b1, "R7", "no change without fall", int'(tx_line), 1);
        man_clk = 1'b0;
        chk(tx_line == 1'b1, "R7", "before edge registers", int'(tx_line), 1);
        @(negedge clk);
        chk(tx_line == 1'b0, "R7", "start one cycle after fall", int'(tx_line), 0);
        man_clk = 1'b1;
        repeat (2) @(negedge clk);
        man_clk = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R7", "bit0 after second fall", int'(tx_line), 1);
        gen_clk = 1'b0;
        ph = 0;
        gen_en = 1'b1;
        while (!tx_empty) @(negedge clk);
        wait_falls(2);

        cl = 2'b00; pe = 0; ss = 2'b00; fs = 2'b00;
        run_frames("R3", 1, 8'hB3, 8'h00, 0);
        cl = 2'b11; fs = 2'b01;
        run_frames("R3", 1, 8'h5A, 8'h00, 0);
        cl = 2'b10; pe = 1; po = 0; fs = 2'b00;
        run_frames("R4", 2, 8'h35, 8'h7F, 0);
        po = 1;
        run_frames("R4", 2, 8'h35, 8'h00, 0);
        pe = 0; cl = 2'b11; ss = 2'b10; fs = 2'b01;
        run_frames("R5", 2, 8'hC3, 8'h18, 0);
        ss = 2'b01;
        run_frames("R6", 2, 8'hA5, 8'h3C, 0);
        fs = 2'b00;
        run_frames("R6", 2, 8'h96, 8'h69, 0);
        fs = 2'b10; ss = 2'b00; cl = 2'b01;
        run_frames("R6", 1, 8'h2D, 8'h00, 0);
        fs = 2'b00; cl = 2'b11; pe = 1; po = 0;
        run_frames("R2", 1, 8'h81, 8'h7E, 1);
        fs = 2'b01;
        run_frames("R8 R12", 1, 8'hE7, 8'h00, 2);
        pe = 0;

        // R11 break: continuous low, then back to idle high
        @(negedge clk);
        brk = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b0, "R11", "line low after break", int'(tx_line), 0);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tx_line != 1'b0) bad = bad + 1;
        end
        chk(bad == 0, "R11", "break held low", bad, 0);
        brk = 1'b0;
        @(negedge clk);
        chk(tx_line == 1'b1, "R11", "idle after break", int'(tx_line), 1);

        for (int k = 0; k < 12; k++) begin
            int r = int'($urandom_range(0, 3));
            cl = 2'($urandom_range(0, 3));
            pe = 1'($urandom_range(0, 1));
            po = 1'($urandom_range(0, 1));
            ss = 2'($urandom_range(0, 3));
            fs = (r == 3) ? 2'b10 : 2'(r & 1);
            run_frames("R3 R4 R5 R6 R9", int'($urandom_range(1, 2)), 8'($urandom), 8'($urandom), 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule